// File: doc/BRIEF.md
# Multicore Coherency-Unit Register Bank

This block is the 32-bit memory-mapped configuration bank of a coherency unit shared by up to four processor cores. A bus master writes and reads word registers in a 256-byte window. Each write carries the index of the core that issues it, so the bank can refuse writes from individual cores. A core that writes 0 to its bit in the access register locks itself out of all register writes until the next reset. Reads are combinational on the word address and are never gated.

Several fields are not storage. They are computed live from parameters or loaded values: the core count, the mask of cores taking part in shared-memory operation, and a flag that shows whether a secondary master-port range is defined. The two master-port filter bounds, the two peripheral-port filter bounds and the filter-enable flag come from strap inputs. They load once, on the first start pulse after reset. The bounds themselves are not reset, so their values survive a reset.

Top module: `coh_regbank`

## Requirements
- R1: After reset, the control register (word offset 0x00) reads 0, and the access register (0x50) reads 1 in bit c for every present core c and 0 above.
- R2: In the control register, bit 0 is a read/write unit-enable flag and bit 1 reads the loaded filter-enable flag. Every other bit reads 0, whatever value is written.
- R3: The configuration register (0x04) reads the core count minus one in bits [1:0] and the present-core mask ANDed with parameter SMP_MASK in bits [7:4]. Bits [30:8] and [3:2] read 0.
- R4: Configuration bit 31 reads 1 exactly when the loaded master start bound and the loaded master end bound are both nonzero as full 32-bit values, including bits that read back masked.
- R5: Writing 0 to bit c of the access register locks core c. Writing 1 has no effect, and a locked bit stays 0 until reset.
- R6: A write from a locked core, or from a core index at or above the core count, changes no register. A write from an unlocked present core takes effect on the next clock edge.
- R7: The filter registers are read-only: master start at 0x40, master end at 0x44, peripheral start at 0x48 and peripheral end at 0x4C. Each reads its loaded bound with bits [19:0] forced to 0.
- R8: The non-secure access register (0x54) reads 0x00000FFF, and writes to it have no effect.
- R9: The first start pulse after reset loads the filter-enable flag and all four bounds from the straps. Later start pulses change nothing until the next reset.
- R10: Reset clears all locks, the unit-enable flag, the filter-enable flag and the started state. It leaves the four loaded bounds unchanged.
- R11: Every other offset reads 0 and ignores writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Start request; loads straps once per reset |
| strapFiltEn | input | 1 | Strap value for the filter-enable flag |
| strapMstStart | input | 32 | Strap value for the master filter start bound |
| strapMstEnd | input | 32 | Strap value for the master filter end bound |
| strapPerStart | input | 32 | Strap value for the peripheral filter start bound |
| strapPerEnd | input | 32 | Strap value for the peripheral filter end bound |
| busAddr | input | 8 | Byte address in the window, used for both read and write |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busCoreIdx | input | 2 | Index of the core that issues the write |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The assertions assume that busCoreIdx is stable and meaningful whenever busWrEn is high. They also assume the bounds have been loaded before anything compares configuration bit 31. The bench drives every write with an explicit core index and holds it for the full cycle. It pulses start before any sweep that compares bound-dependent fields, and it checks only the access and control registers in the window between reset and the first start.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int MAX_CORES = 4;
  localparam int WORD_AW   = 6;
  localparam int RANGE_CNT = 4;

  localparam logic [WORD_AW-1:0] OFF_CTRL   = 6'h00;
  localparam logic [WORD_AW-1:0] OFF_CFG    = 6'h01;
  localparam logic [WORD_AW-1:0] OFF_MST_LO = 6'h10;
  localparam logic [WORD_AW-1:0] OFF_MST_HI = 6'h11;
  localparam logic [WORD_AW-1:0] OFF_PER_LO = 6'h12;
  localparam logic [WORD_AW-1:0] OFF_PER_HI = 6'h13;
  localparam logic [WORD_AW-1:0] OFF_ACC    = 6'h14;
  localparam logic [WORD_AW-1:0] OFF_NSAC   = 6'h15;

  typedef struct packed {
    logic wrCtrl;
    logic wrAcc;
    logic loadStraps;
  } cohStrobe_t;
endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 busWrEn,
  input  logic [WORD_AW-1:0]   wordAddr,
  input  logic [1:0]           coreIdx,
  input  logic [MAX_CORES-1:0] accWrBits,
  output cohStrobe_t           strb,
  output logic [MAX_CORES-1:0] unlockVec
);
  localparam logic [2:0] CORE_CNT = 3'(NUM_CORES);

  logic started;
  logic coreOk;
  logic wrOk;

  assign coreOk = ({1'b0, coreIdx} < CORE_CNT) && unlockVec[coreIdx];
  assign wrOk   = busWrEn && coreOk;

  always_comb begin
    strb            = '0;
    strb.wrCtrl     = wrOk && (wordAddr == OFF_CTRL);
    strb.wrAcc      = wrOk && (wordAddr == OFF_ACC);
    strb.loadStraps = startPulse && !started;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                started <= 1'b0;
    else if (strb.loadStraps) started <= 1'b1;
  end

  for (genvar c = 0; c < MAX_CORES; c++) begin : g_lock
    if (c < NUM_CORES) begin : g_present
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             unlockVec[c] <= 1'b1;
        else if (strb.wrAcc && !accWrBits[c])  unlockVec[c] <= 1'b0;
      end

      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        !unlockVec[c] |=> !unlockVec[c]); // R5
    end else begin : g_absent
      assign unlockVec[c] = 1'b0;
    end
  end

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStraps |=> !strb.loadStraps); // R9
endmodule

// File: rtl/coh_dpath.sv
module coh_dpath
  import coh_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter logic [3:0]  SMP_MASK  = 4'hF,
  parameter int          MASK_LOW  = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cohStrobe_t                 strb,
  input  logic                       enWrBit,
  input  logic                       strapFiltEn,
  input  logic [RANGE_CNT-1:0][31:0] strapRange,
  input  logic [WORD_AW-1:0]         wordAddr,
  input  logic                       busWrEn,
  input  logic [1:0]                 coreIdx,
  input  logic [MAX_CORES-1:0]       unlockVec,
  output logic [31:0]                rdData
);
  localparam logic [4:0]  PRESENT_W  = (5'd1 << NUM_CORES) - 5'd1;
  localparam logic [3:0]  PRESENT    = PRESENT_W[3:0];
  localparam logic [1:0]  CNT_M1     = 2'(NUM_CORES - 1);
  localparam logic [31:0] LOW_MASK   = (32'd1 << MASK_LOW) - 32'd1;
  localparam logic [31:0] NSAC_VALUE = 32'h0000_0FFF;
  localparam logic [2:0]  CORE_CNT   = 3'(NUM_CORES);

  logic                       enableBit;
  logic                       filtEnBit;
  logic [RANGE_CNT-1:0][31:0] rangeReg;
  logic                       mstDefined;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      filtEnBit <= 1'b0;
    end else begin
      if (strb.wrCtrl)     enableBit <= enWrBit;
      if (strb.loadStraps) filtEnBit <= strapFiltEn;
    end
  end

  for (genvar g = 0; g < RANGE_CNT; g++) begin : g_range
    always_ff @(posedge clk) begin
      if (strb.loadStraps) rangeReg[g] <= strapRange[g];
    end
  end

  assign mstDefined = (rangeReg[0] != 32'd0) && (rangeReg[1] != 32'd0);

  always_comb begin
    rdData = 32'd0;
    case (wordAddr)
      OFF_CTRL:   rdData = {30'd0, filtEnBit, enableBit};
      OFF_CFG:    rdData = {mstDefined, 23'd0, PRESENT & SMP_MASK, 2'b00, CNT_M1};
      OFF_MST_LO: rdData = rangeReg[0] & ~LOW_MASK;
      OFF_MST_HI: rdData = rangeReg[1] & ~LOW_MASK;
      OFF_PER_LO: rdData = rangeReg[2] & ~LOW_MASK;
      OFF_PER_HI: rdData = rangeReg[3] & ~LOW_MASK;
      OFF_ACC:    rdData = {28'd0, unlockVec};
      OFF_NSAC:   rdData = NSAC_VALUE;
      default:    rdData = 32'd0;
    endcase
  end

  AST_FILT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wordAddr >= OFF_MST_LO && wordAddr <= OFF_PER_HI) |-> (rdData[19:0] == 20'd0)); // R7

  AST_NSAC_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (wordAddr == OFF_NSAC) |-> (rdData == 32'h0000_0FFF)); // R8

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (({1'b0, coreIdx} >= CORE_CNT) || !unlockVec[coreIdx])) |=> $stable(enableBit)); // R6

  AST_STRAPS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStraps |=> $stable(rangeReg)); // R9
endmodule

// File: rtl/coh_regbank.sv
module coh_regbank
  import coh_pkg::*;
#(
  parameter int         NUM_CORES = 4,
  parameter logic [3:0] SMP_MASK  = 4'hF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        strapFiltEn,
  input  logic [31:0] strapMstStart,
  input  logic [31:0] strapMstEnd,
  input  logic [31:0] strapPerStart,
  input  logic [31:0] strapPerEnd,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  input  logic [1:0]  busCoreIdx,
  output logic [31:0] busRdData
);
  cohStrobe_t                 strb;
  logic [MAX_CORES-1:0]       unlockVec;
  logic [WORD_AW-1:0]         wordAddr;
  logic [RANGE_CNT-1:0][31:0] strapRange;
  logic                       unusedBits;

  assign wordAddr   = busAddr[7:2];
  assign unusedBits = ^{busAddr[1:0], busWrData[31:MAX_CORES]};
  assign strapRange = {strapPerEnd, strapPerStart, strapMstEnd, strapMstStart};

  coh_ctrl #(.NUM_CORES(NUM_CORES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .busWrEn    (busWrEn),
    .wordAddr   (wordAddr),
    .coreIdx    (busCoreIdx),
    .accWrBits  (busWrData[MAX_CORES-1:0]),
    .strb       (strb),
    .unlockVec  (unlockVec)
  );

  coh_dpath #(.NUM_CORES(NUM_CORES), .SMP_MASK(SMP_MASK)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .enWrBit     (busWrData[0]),
    .strapFiltEn (strapFiltEn),
    .strapRange  (strapRange),
    .wordAddr    (wordAddr),
    .busWrEn     (busWrEn),
    .coreIdx     (busCoreIdx),
    .unlockVec   (unlockVec),
    .rdData      (busRdData)
  );
endmodule

// File: tb/test_coh_regbank.sv
module test_coh_regbank;
  localparam int         CLK_PERIOD = 10;
  localparam logic [3:0] SMP        = 4'b1011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        strapFiltEn = 1'b0;
  logic [31:0] strapMstStart = '0, strapMstEnd = '0, strapPerStart = '0, strapPerEnd = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [1:0]  busCoreIdx = '0;
  logic [31:0] busRdData;

  int nChecks = 0;
  int nFails  = 0;

  logic        mEn, mFilt, mStarted, mLoaded;
  logic [3:0]  mUnlock;
  logic [31:0] mRange [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_regbank #(.NUM_CORES(4), .SMP_MASK(SMP)) i_coh_regbank (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .strapFiltEn(strapFiltEn),
    .strapMstStart(strapMstStart), .strapMstEnd(strapMstEnd),
    .strapPerStart(strapPerStart), .strapPerEnd(strapPerEnd),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busCoreIdx(busCoreIdx), .busRdData(busRdData)
  );

  function automatic logic [31:0] expRd(input logic [5:0] w);
    logic [31:0] v;
    case (w)
      6'h00: v = {30'd0, mFilt, mEn};
      6'h01: v = {(mRange[0] != 0) && (mRange[1] != 0), 23'd0, 4'hF & SMP, 2'b00, 2'd3};
      6'h10, 6'h11, 6'h12, 6'h13: v = mRange[w - 6'h10] & 32'hFFF0_0000;
      6'h14: v = {28'd0, mUnlock};
      6'h15: v = 32'h0000_0FFF;
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  function automatic string tagFor(input logic [5:0] w);
    case (w)
      6'h00: return "R2";
      6'h01: return "R3";
      6'h10, 6'h11, 6'h12, 6'h13: return "R7";
      6'h14: return "R5";
      6'h15: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    busAddr = a;
    #1;
    e = expRd(a[7:2]);
    nChecks++;
    if (busRdData !== e) begin
      nFails++;
      $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", tag, a, busRdData, e);
    end
  endtask

  task automatic sweep(input string why);
    for (int w = 0; w < 64; w++) begin
      logic [5:0] wa = 6'(w);
      if (!mLoaded && (wa == 6'h01 || (wa >= 6'h10 && wa <= 6'h13))) continue;
      chk({wa, 2'(w)}, (why == "") ? tagFor(wa) : why);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] core);
    if (mUnlock[core]) begin
      if (a[7:2] == 6'h00) mEn = d[0];
      if (a[7:2] == 6'h14) mUnlock = mUnlock & d[3:0];
    end
    @(negedge clk);
    busAddr = a; busWrData = d; busCoreIdx = core; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic start(input logic f, input logic [31:0] a, b, c, d);
    if (!mStarted) begin
      mFilt = f; mRange[0] = a; mRange[1] = b; mRange[2] = c; mRange[3] = d;
      mStarted = 1'b1; mLoaded = 1'b1;
    end
    @(negedge clk);
    strapFiltEn = f; strapMstStart = a; strapMstEnd = b; strapPerStart = c; strapPerEnd = d;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    mEn = 0; mFilt = 0; mStarted = 0; mUnlock = 4'hF;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    mLoaded = 1'b0;
    for (int i = 0; i < 4; i++) mRange[i] = '0;
    doReset();
    chk(8'h00, "R1");
    chk(8'h50, "R1");
    chk(8'h54, "R8");

    // R9: first start loads straps
    start(1'b1, 32'h1234_5678, 32'hABCD_E000, 32'h0010_0FFF, 32'hFFFF_FFFF);
    sweep("");
    // R9: second start ignored
    start(1'b0, 32'h0, 32'h5555_5555, 32'h7777_7777, 32'h0);
    sweep("R9");

    // R2: control bits
    wr(8'h00, 32'hFFFF_FFFF, 2'd0); chk(8'h00, "R2");
    wr(8'h03, 32'hFFFF_FFFE, 2'd1); chk(8'h00, "R2");

    // R11, R7, R8: writes to read-only and unused offsets
    for (int w = 1; w < 64; w++) if (w != 6'h14 && w != 0) wr({6'(w), 2'b01}, 32'hFFFF_FFFF, 2'(w));
    sweep("R11");

    // R5: writing ones does not lock
    wr(8'h50, 32'hFFFF_FFFF, 2'd1); chk(8'h50, "R5");
    wr(8'h50, 32'hFFFF_FFFE, 2'd0); chk(8'h50, "R5");
    // R6: locked core writes discarded
    wr(8'h00, 32'h1, 2'd0); chk(8'h00, "R6");
    wr(8'h50, 32'h0, 2'd0); chk(8'h50, "R6");
    wr(8'h50, 32'hF, 2'd2); chk(8'h50, "R5");
    wr(8'h50, 32'hB, 2'd3); chk(8'h50, "R5");
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) begin
        wr(8'h00, 32'(r ^ c ^ 1), 2'(c));
        chk(8'h00, "R6");
      end
    wr(8'h50, 32'h0, 2'd1); chk(8'h50, "R5");
    wr(8'h50, 32'h0, 2'd3); chk(8'h50, "R5");
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, 32'(c & 1), 2'(c)); chk(8'h00, "R6");
    end

    // R10: reset clears locks and flags, bounds survive
    doReset();
    sweep("R10");
    // R4: master end zero
    start(1'b0, 32'h0000_0005, 32'h0, 32'h0, 32'h0);
    chk(8'h04, "R4"); sweep("");
    doReset();
    // R4: nonzero bounds that read masked as zero
    start(1'b1, 32'h0000_0001, 32'h000F_FFFF, 32'hFFF0_0001, 32'h8000_0000);
    chk(8'h04, "R4"); chk(8'h40, "R4"); sweep("");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule